// File: doc/BRIEF.md
# Minimum Dwell-Time Conditioner

This block sits between a fast comparator decision and the feedback pin of a switching regulator. The comparator can produce a rapid stream of "above" / "below" decisions. Each change of the conditioned output therefore holds the new level for a programmable minimum number of clock cycles. The minimum for the high level and the minimum for the low level are set separately.

Once the minimum for the present level has run out, the block no longer imposes any delay. The output then follows the synchronized input on the next clock edge, so regulation is not reduced to sampling at a fixed interval. Any input level that reaches the dwell logic while the output is idle starts a full new minimum, even if that level lasts for only one clock sample.

The raw input first passes through a two-flop synchronizer. Minimum times are given as clock-cycle counts, for example 500 cycles at 100 MHz for 5 µs. One instance serves one channel.

Top module: `min_dwell_conditioner`

## Requirements
- R1: While `rst` is high the output is 0. Each reset edge starts a low minimum, so after `rst` falls the output cannot rise until `max(minLowCycles,1)` clock edges have passed.
- R2: After a rise, the output stays high for at least `max(minHighCycles,1)` clock cycles.
- R3: After a fall, the output stays low for at least `max(minLowCycles,1)` clock cycles.
- R4: The high and low minimums come from two independent ports, and a value of 0 acts as 1. Each value is taken when a dwell of that level starts, and the bench changes them only while `rst` is high.
- R5: Once the present minimum has expired, a synchronized input at the opposite level changes the output on the next edge. A `rawIn` change set up before edge k appears on `condOut` after edge k+2.
- R6: An input high that lasts for a single clock sample, arriving while the output is low and idle, produces a complete high dwell of the programmed minimum.
- R7: When a minimum expires, the output acts only on the current synchronized input level. An opposite excursion that began and ended inside the dwell is not replayed.
- R8: While the synchronized input equals the output, the output does not change, however long that lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rawIn | input | 1 | Unsynchronized comparator decision |
| minHighCycles | input | CNT_W | Minimum high dwell in clock cycles (0 acts as 1) |
| minLowCycles | input | CNT_W | Minimum low dwell in clock cycles (0 acts as 1) |
| condOut | output | 1 | Conditioned output to the regulator feedback |

## Verification
The assertions check three things on every cycle. No fall of the output comes before the high minimum has elapsed, and no rise comes before the low minimum has elapsed. An expired dwell with an opposite synchronized input always produces a change on the next edge, and a matching input never does. Other behaviour can only be shown by the bench's scenarios against its reference model: the exact three-edge latency from `rawIn`, the full dwell produced by a single-sample pulse, and the fact that an excursion which has already reversed is not replayed. The same holds for the effect of a zero minimum and for the delayed first rise after reset.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  // Strobes from the control to the datapath, evaluated once per cycle.
  typedef struct packed {
    logic loadCnt;  // load the dwell counter with the minimum of selHigh's level
    logic selHigh;  // 1: use the high minimum, 0: use the low minimum
    logic decCnt;   // count one cycle of the running dwell
    logic setOut;   // write outVal into the output register
    logic outVal;   // level written on setOut
  } dwellStrobes_t;

endpackage

// File: rtl/dwell_sync.sv
module dwell_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/dwell_control.sv
module dwell_control
  import dwell_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          syncIn,
  input  logic          curOut,
  input  logic          cntZero,
  output dwellStrobes_t ctl
);

  always_comb begin
    ctl = '0;
    if (rst) begin
      // Reset forces a low level and opens a low dwell.
      ctl.setOut  = 1'b1;
      ctl.outVal  = 1'b0;
      ctl.loadCnt = 1'b1;
      ctl.selHigh = 1'b0;
    end else if (!cntZero) begin
      ctl.decCnt = 1'b1;
    end else if (syncIn != curOut) begin
      // Dwell over: act on the level present now, start the next dwell.
      ctl.setOut  = 1'b1;
      ctl.outVal  = syncIn;
      ctl.loadCnt = 1'b1;
      ctl.selHigh = syncIn;
    end
  end

  AST_NO_TOGGLE_IN_DWELL: assert property (@(posedge clk) disable iff (rst)
    !cntZero |=> $stable(curOut)) else $error("toggle inside dwell"); // R2

endmodule

// File: rtl/dwell_datapath.sv
module dwell_datapath
  import dwell_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dwellStrobes_t    ctl,
  input  logic [CNT_W-1:0] minHigh,
  input  logic [CNT_W-1:0] minLow,
  output logic             condOut,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] dwellCnt;
  logic [CNT_W-1:0] pickMin;
  logic [CNT_W-1:0] loadVal;

  // A dwell of N cycles needs N-1 further edges before the next change.
  assign pickMin = ctl.selHigh ? minHigh : minLow;
  assign loadVal = (pickMin == '0) ? '0 : pickMin - CNT_ONE;
  assign cntZero = (dwellCnt == '0);

  always_ff @(posedge clk) begin
    if (ctl.loadCnt)     dwellCnt <= loadVal;
    else if (ctl.decCnt) dwellCnt <= dwellCnt - CNT_ONE;
    if (ctl.setOut)      condOut  <= ctl.outVal;
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !condOut) else $error("output not low after reset"); // R1

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    ctl.decCnt |-> !cntZero) else $error("count below zero"); // R3

endmodule

// File: rtl/min_dwell_conditioner.sv
module min_dwell_conditioner
  import dwell_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rawIn,
  input  logic [CNT_W-1:0] minHighCycles,
  input  logic [CNT_W-1:0] minLowCycles,
  output logic             condOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic          syncIn;
  logic          cntZero;
  dwellStrobes_t ctl;

  dwell_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(syncIn)
  );

  dwell_control i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .syncIn (syncIn),
    .curOut (condOut),
    .cntZero(cntZero),
    .ctl    (ctl)
  );

  dwell_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .minHigh(minHighCycles),
    .minLow (minLowCycles),
    .condOut(condOut),
    .cntZero(cntZero)
  );

  // Observation logic for the assertions: age of the present output level.
  logic             outPrev;
  logic [CNT_W-1:0] ageReg;
  logic [CNT_W-1:0] levelAge;
  logic [CNT_W-1:0] effHigh;
  logic [CNT_W-1:0] effLow;
  logic [CNT_W-1:0] effCur;

  assign effHigh = (minHighCycles == '0) ? CNT_ONE : minHighCycles;
  assign effLow  = (minLowCycles  == '0) ? CNT_ONE : minLowCycles;
  assign effCur  = condOut ? effHigh : effLow;

  always_comb begin
    if (condOut != outPrev)  levelAge = CNT_ONE;
    else if (ageReg == '1)   levelAge = '1;
    else                     levelAge = ageReg + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outPrev <= 1'b0;
      ageReg  <= '0;
    end else begin
      outPrev <= condOut;
      ageReg  <= levelAge;
    end
  end

  AST_HIGH_DWELL: assert property (@(posedge clk) disable iff (rst)
    $fell(condOut) |-> $past(levelAge) >= $past(effHigh)) else $error("high dwell short"); // R2

  AST_LOW_DWELL: assert property (@(posedge clk) disable iff (rst)
    $rose(condOut) |-> $past(levelAge) >= $past(effLow)) else $error("low dwell short"); // R3

  AST_FOLLOW_EXPIRED: assert property (@(posedge clk) disable iff (rst)
    (levelAge >= effCur && syncIn != condOut) |=> condOut != $past(condOut)) else $error("no follow"); // R5

  AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (rst)
    (syncIn == condOut) |=> $stable(condOut)) else $error("spurious change"); // R8

endmodule

// File: tb/test_min_dwell_conditioner.sv
module test_min_dwell_conditioner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rawIn = 1'b0;
  logic [15:0] minHigh = 16'd5;
  logic [15:0] minLow  = 16'd8;
  logic        condOut;

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  bit    done   = 1'b0;

  always #5 clk = ~clk;

  min_dwell_conditioner #(.CNT_W(16), .SYNC_STAGES(2)) i_min_dwell_conditioner (
    .clk          (clk),
    .rst          (rst),
    .rawIn        (rawIn),
    .minHighCycles(minHigh),
    .minLowCycles (minLow),
    .condOut      (condOut)
  );

  // Behavioural reference: two-sample input delay, level age, minimum rule.
  int mS1 = 0, mS2 = 0, mOut = 0, mAge = 1, effv;
  always @(posedge clk) begin
    if (rst) begin
      mOut = 0; mAge = 1; mS1 = 0; mS2 = 0;
    end else begin
      if (mOut == 1) effv = (minHigh == 0) ? 1 : int'(minHigh);
      else           effv = (minLow  == 0) ? 1 : int'(minLow);
      if (mAge >= effv && mS2 != mOut) begin
        mOut = mS2; mAge = 1;
      end else begin
        mAge++;
      end
      mS2 = mS1;
      mS1 = int'(rawIn);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (condOut !== mOut[0]) begin
        fails++;
        $display("FAIL %s: condOut=%0b expected %0b at %0t", curReq, condOut, mOut[0], $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Negedges until condOut equals lvl (bounded).
  task automatic waitLevel(input logic lvl, output int n);
    n = 0;
    while (condOut !== lvl && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic doReset(input int hi, input int lo);
    rst = 1'b1; rawIn = 1'b0;
    minHigh = 16'(hi); minLow = 16'(lo);
    cyc(3);
  endtask

  int n;
  logic [15:0] lfsr;

  initial begin
    @(negedge clk);
    // R1: reset state and first-rise delay.
    curReq = "R1";
    doReset(5, 8);
    chk(condOut == 1'b0, "R1 reset output", int'(condOut), 0);
    rst = 1'b0; rawIn = 1'b1;
    waitLevel(1'b1, n);
    chk(n == 8, "R1 first rise delay", n, 8);

    // R8: a long stable high is held.
    curReq = "R8";
    cyc(1);
    for (int i = 0; i < 20; i++) begin
      chk(condOut == 1'b1, "R8 held while input matches", int'(condOut), 1);
      cyc(1);
    end

    // R5: expired dwell, fall appears three edges after the change.
    curReq = "R5";
    rawIn = 1'b0;
    waitLevel(1'b0, n);
    chk(n == 3, "R5 follow latency", n, 3);

    // R7: excursion inside the low dwell is not replayed.
    curReq = "R7";
    rawIn = 1'b1; cyc(1); rawIn = 1'b0;
    n = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(1);
      if (condOut) n++;
    end
    chk(n == 0, "R7 reverted excursion ignored", n, 0);

    // R6/R2: single-sample pulse while idle gives a full high dwell.
    curReq = "R6";
    rawIn = 1'b1; cyc(1); rawIn = 1'b0;
    waitLevel(1'b1, n);
    chk(n == 2, "R6 pulse rise latency", n, 2);
    n = 0;
    while (condOut && n < 100) begin cyc(1); n++; end
    chk(n == 5, "R6 R2 high dwell length", n, 5);

    // R3: input back high at once, low dwell still enforced.
    curReq = "R3";
    rawIn = 1'b1;
    waitLevel(1'b1, n);
    chk(n == 8, "R3 low dwell length", n, 8);
    rawIn = 1'b0; cyc(40);

    // R4: zero high minimum acts as one, independent long low minimum.
    curReq = "R4";
    doReset(0, 12);
    rst = 1'b0; cyc(20);
    rawIn = 1'b1; cyc(1); rawIn = 1'b0;
    waitLevel(1'b1, n);
    n = 0;
    while (condOut && n < 100) begin cyc(1); n++; end
    chk(n == 1, "R4 zero high minimum", n, 1);
    rawIn = 1'b1;
    waitLevel(1'b1, n);
    chk(n == 12, "R4 independent low minimum", n, 12);
    rawIn = 1'b0; cyc(30);

    // R2 R3 R5: pseudo-random input against the model.
    curReq = "R2 R3 R5";
    doReset(3, 7);
    rst = 1'b0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) rawIn = ~rawIn;
      cyc(1);
    end

    // R1: reset in the middle of activity.
    curReq = "R1";
    rawIn = 1'b1; cyc(30);
    rst = 1'b1; cyc(2);
    chk(condOut == 1'b0, "R1 mid-run reset", int'(condOut), 0);
    rst = 1'b0;
    waitLevel(1'b1, n);
    chk(n == 7, "R1 rise after mid-run reset", n, 7);
    cyc(10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (%s): actual timeout expected completion", curReq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule